// File: doc/BRIEF.md
# Serial Audio Frame and Bit Clock Generator

This block produces the frame clock (LRCLK) and bit clock (BCLK) of a serial audio link from a single master clock (MCLK). A three-bit rate code sets the ratio of MCLK to the frame rate. Each frame holds 64 bit-clock periods, so BCLK is MCLK divided by ratio/64. Some ratios (192, 384 and 768) give divide factors of 3, 6 and 12, which are not powers of two. A master-select input decides whether the block drives the two clock pins. When it is low, the pins belong to an outside source: the block drops its output enables and holds its dividers at zero.

A build parameter chooses between two ratio sets. The wide set suits a conversion path that needs the low ratios of 128 and 192. The narrow set is for a path that only supports 256 and above. An invert input flips MCLK inside the block before any register uses it. This moves every output transition to the other MCLK edge, which keeps BCLK edges from landing on the same instant as the incoming MCLK rising edge.

Changes to the rate code or the master select are only acted on at a frame boundary. Every frame therefore completes at its full length, and no short pulse ever reaches the pins.

Top module: `frame_clock_gen`

## Requirements
- R1: While reset is asserted, and whenever the block is not acting as master, bclkOe and lrclkOe are 0 and bclkOut and lrclkOut are held at 0.
- R2: With masterSel at 1, both output enables are 1 and the block drives the generated clocks.
- R3: In the wide-set build (FULL_SET=1), rateCode selects the LRCLK period in MCLK cycles as follows: 3'b000 gives 128, 3'b001 gives 192, 3'b010 gives 256, 3'b011 gives 384, 3'b100 gives 512 and 3'b101 gives 768.
- R4: In the narrow-set build (FULL_SET=0), codes 3'b010 to 3'b101 behave as in R3, and codes 3'b000, 3'b001, 3'b110 and 3'b111 all give 256.
- R5: In the wide-set build, codes 3'b110 and 3'b111 give 256.
- R6: Each frame contains exactly 64 BCLK periods of d = ratio/64 MCLK cycles each. Within each period, BCLK is low for floor(d/2) cycles and then high for the remaining cycles, so d = 3 gives a 1/3 low, 2/3 high shape.
- R7: LRCLK is low for the first 32 BCLK periods of a frame and high for the last 32. It changes state only on the same MCLK edge on which BCLK falls.
- R8: A rate-code change made during a frame leaves that frame at its old length. The new ratio applies from the next LRCLK falling edge, which is the frame boundary.
- R9: When the block is in the slave state, raising masterSel starts master operation on the next MCLK edge, with a fresh frame beginning at that edge. Dropping masterSel during a frame keeps the enables high until that frame ends, and they fall together with LRCLK.
- R10: With mclkInvert at 0, the outputs change only on rising edges of mclkIn. With mclkInvert at 1, they change only on falling edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclkIn | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rateCode | input | 3 | Ratio select of MCLK to frame rate |
| masterSel | input | 1 | 1: generate and drive the clocks, 0: slave |
| mclkInvert | input | 1 | 1: use the inverted master clock internally |
| bclkOut | output | 1 | Generated bit clock |
| lrclkOut | output | 1 | Generated frame clock |
| bclkOe | output | 1 | Output enable for the bit-clock pin |
| lrclkOe | output | 1 | Output enable for the frame-clock pin |

## Verification
Some properties are checked on every cycle:
- the outputs stay quiet whenever the enables are low;
- an enable never rises into a non-zero clock level;
- LRCLK moves only when BCLK falls;
- the divider count stays below the selected factor;
- the active ratio and the master state cannot change inside a frame.

Other behaviour can only be shown by the bench's scenarios: the absolute frame lengths and duty shapes for each rate code in both builds, and the exact frame on which a rate change or a master drop takes effect. The same holds for the choice of MCLK edge made by the invert input, which the bench observes by sampling between the two edges.

// File: rtl/fclk_pkg.sv
package fclk_pkg;

  localparam int unsigned MAX_RATIO   = 768;
  localparam int unsigned RESET_RATIO = 256;

  typedef struct packed {
    logic restart;  // frame boundary: counters return to zero, settings reload
    logic run;      // master operation active
  } dpCtl_t;

  function automatic int unsigned ratioFor(input logic [2:0] code, input bit fullSet);
    int unsigned r;
    case (code)
      3'b000:  r = fullSet ? 128 : RESET_RATIO;
      3'b001:  r = fullSet ? 192 : RESET_RATIO;
      3'b010:  r = 256;
      3'b011:  r = 384;
      3'b100:  r = 512;
      3'b101:  r = 768;
      default: r = RESET_RATIO;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/fclk_rate_decode.sv
module fclk_rate_decode
  import fclk_pkg::*;
#(
  parameter bit          FULL_SET    = 1'b1,
  parameter int unsigned FRAME_BCLKS = 64,
  parameter int          DIV_W       = 4
) (
  input  logic [2:0]       rateCode,
  output logic [DIV_W-1:0] divReq
);

  generate
    if (FULL_SET) begin : g_full
      always_comb divReq = DIV_W'(ratioFor(rateCode, 1'b1) / FRAME_BCLKS);
    end else begin : g_narrow
      always_comb divReq = DIV_W'(ratioFor(rateCode, 1'b0) / FRAME_BCLKS);
    end
  endgenerate

endmodule

// File: rtl/fclk_ctrl.sv
module fclk_ctrl
  import fclk_pkg::*;
#(
  parameter int                DIV_W     = 4,
  parameter logic [DIV_W-1:0]  RESET_DIV = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             masterSel,
  input  logic [DIV_W-1:0] divReq,
  input  logic             frameEnd,
  output dpCtl_t           ctl,
  output logic [DIV_W-1:0] activeDiv,
  output logic             activeMaster
);

  logic restartNow;

  assign restartNow = !activeMaster || frameEnd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeMaster <= 1'b0;
      activeDiv    <= RESET_DIV;
    end else if (restartNow) begin
      activeMaster <= masterSel;
      activeDiv    <= divReq;
    end
  end

  always_comb begin
    ctl.restart = restartNow;
    ctl.run     = activeMaster;
  end

  // R8
  div_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (activeMaster && !frameEnd) |=> $stable(activeDiv));

  // R9
  master_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (activeMaster && !frameEnd) |=> activeMaster);

endmodule

// File: rtl/fclk_datapath.sv
module fclk_datapath
  import fclk_pkg::*;
#(
  parameter int unsigned FRAME_BCLKS = 64,
  parameter int          DIV_W       = 4,
  localparam int         CNT_W       = $clog2(FRAME_BCLKS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           ctl,
  input  logic [DIV_W-1:0] divSel,
  output logic             frameEnd,
  output logic             bclkQ,
  output logic             lrclkQ
);

  logic [DIV_W-1:0] divCnt, divCntNxt, halfDiv;
  logic [CNT_W-1:0] bitCnt, bitCntNxt;
  logic             lastDiv;

  assign halfDiv  = divSel >> 1;
  assign lastDiv  = (divCnt == divSel - DIV_W'(1));
  assign frameEnd = ctl.run && lastDiv && (bitCnt == CNT_W'(FRAME_BCLKS - 1));

  always_comb begin
    if (ctl.restart || !ctl.run) begin
      divCntNxt = '0;
      bitCntNxt = '0;
    end else if (lastDiv) begin
      divCntNxt = '0;
      bitCntNxt = bitCnt + CNT_W'(1);
    end else begin
      divCntNxt = divCnt + DIV_W'(1);
      bitCntNxt = bitCnt;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      bitCnt <= '0;
      bclkQ  <= 1'b0;
      lrclkQ <= 1'b0;
    end else begin
      divCnt <= divCntNxt;
      bitCnt <= bitCntNxt;
      bclkQ  <= (divCntNxt >= halfDiv);
      lrclkQ <= bitCntNxt[CNT_W-1];
    end
  end

  // R6
  div_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    divCnt < divSel);

  // R7
  lr_on_bfall_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(lrclkQ) |-> $fell(bclkQ));

endmodule

// File: rtl/frame_clock_gen.sv
module frame_clock_gen
  import fclk_pkg::*;
#(
  parameter bit          FULL_SET    = 1'b1,
  parameter int unsigned FRAME_BCLKS = 64
) (
  input  logic       mclkIn,
  input  logic       rstN,
  input  logic [2:0] rateCode,
  input  logic       masterSel,
  input  logic       mclkInvert,
  output logic       bclkOut,
  output logic       lrclkOut,
  output logic       bclkOe,
  output logic       lrclkOe
);

  localparam int               DIV_W     = $clog2(MAX_RATIO / FRAME_BCLKS + 1);
  localparam logic [DIV_W-1:0] RESET_DIV = DIV_W'(RESET_RATIO / FRAME_BCLKS);

  logic             mclkInt;
  logic [DIV_W-1:0] divReq, activeDiv;
  logic             frameEnd, activeMaster, bclkQ, lrclkQ;
  dpCtl_t           ctl;

  assign mclkInt = mclkIn ^ mclkInvert;

  fclk_rate_decode #(.FULL_SET(FULL_SET), .FRAME_BCLKS(FRAME_BCLKS), .DIV_W(DIV_W)) u_dec (
    .rateCode (rateCode),
    .divReq   (divReq)
  );

  fclk_ctrl #(.DIV_W(DIV_W), .RESET_DIV(RESET_DIV)) u_ctrl (
    .clk          (mclkInt),
    .rstN         (rstN),
    .masterSel    (masterSel),
    .divReq       (divReq),
    .frameEnd     (frameEnd),
    .ctl          (ctl),
    .activeDiv    (activeDiv),
    .activeMaster (activeMaster)
  );

  fclk_datapath #(.FRAME_BCLKS(FRAME_BCLKS), .DIV_W(DIV_W)) u_dp (
    .clk      (mclkInt),
    .rstN     (rstN),
    .ctl      (ctl),
    .divSel   (activeDiv),
    .frameEnd (frameEnd),
    .bclkQ    (bclkQ),
    .lrclkQ   (lrclkQ)
  );

  assign bclkOut  = bclkQ;
  assign lrclkOut = lrclkQ;
  assign bclkOe   = activeMaster;
  assign lrclkOe  = activeMaster;

  // R1
  slave_quiet_chk: assert property (@(posedge mclkInt) disable iff (!rstN)
    !bclkOe |-> (!bclkOut && !lrclkOut));

  // R2
  oe_rise_chk: assert property (@(posedge mclkInt) disable iff (!rstN)
    $rose(bclkOe) |-> (!bclkOut && !lrclkOut && lrclkOe));

  // R9
  oe_drop_chk: assert property (@(posedge mclkInt) disable iff (!rstN)
    $fell(bclkOe) |-> $fell(lrclkOut));

endmodule

// File: tb/sim_frame_clock_gen.sv
module sim_frame_clock_gen;

  logic       mclk = 1'b0;
  logic       rstN;
  logic [2:0] code;
  logic       master;
  logic       inv;
  logic       b0, l0, bo0, lo0;
  logic       b1, l1, bo1, lo1;
  int         total = 0;
  int         bad   = 0;

  always #2 mclk = ~mclk;

  frame_clock_gen #(.FULL_SET(1'b1)) u0 (
    .mclkIn(mclk), .rstN(rstN), .rateCode(code), .masterSel(master), .mclkInvert(inv),
    .bclkOut(b0), .lrclkOut(l0), .bclkOe(bo0), .lrclkOe(lo0));

  frame_clock_gen #(.FULL_SET(1'b0)) u1 (
    .mclkIn(mclk), .rstN(rstN), .rateCode(code), .masterSel(master), .mclkInvert(inv),
    .bclkOut(b1), .lrclkOut(l1), .bclkOe(bo1), .lrclkOe(lo1));

  // code, divide factor in wide build, divide factor in narrow build
  localparam int VEC [8][3] = '{
    '{0, 2, 4}, '{1, 3, 4}, '{2, 4, 4}, '{3, 6, 6},
    '{4, 8, 8}, '{5, 12, 12}, '{6, 4, 4}, '{7, 4, 4}};

  function automatic logic bOf(int i);  return (i == 0) ? b0 : b1;  endfunction
  function automatic logic lOf(int i);  return (i == 0) ? l0 : l1;  endfunction
  function automatic logic oeOf(int i); return (i == 0) ? (bo0 & lo0) : (bo1 & lo1); endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge mclk);
    #1;
  endtask

  task automatic waitFall(input int idx, output int cnt);
    logic prevL, curL;
    prevL = lOf(idx);
    cnt = 0;
    for (int k = 0; k < 4000; k++) begin
      tick();
      cnt++;
      curL = lOf(idx);
      if (prevL && !curL) break;
      prevL = curL;
    end
  endtask

  // Called on the sample right after a frame boundary.
  task automatic frameStats(input int idx, input int d, input string req);
    logic prevB, prevL, curB, curL;
    int n, bRise, bHigh, lHigh, badEdge;
    prevB = bOf(idx); prevL = lOf(idx);
    n = 0; bRise = 0; bHigh = 0; lHigh = 0; badEdge = 0;
    for (int k = 0; k < 4000; k++) begin
      tick();
      n++;
      curB = bOf(idx); curL = lOf(idx);
      if (curL != prevL && !(prevB && !curB)) badEdge++;
      if (prevL && !curL) break;
      if (curB) bHigh++;
      if (curL) lHigh++;
      if (!prevB && curB) bRise++;
      prevB = curB; prevL = curL;
    end
    check(n == 64 * d, {req, " frame length"}, n, 64 * d);
    // R6
    check(bRise == 64, "R6 bclk periods per frame", bRise, 64);
    check(bHigh == 64 * (d - d / 2), "R6 bclk high cycles", bHigh, 64 * (d - d / 2));
    // R7
    check(lHigh == 32 * d, "R7 lrclk high cycles", lHigh, 32 * d);
    check(badEdge == 0, "R7 lrclk moved off bclk fall", badEdge, 0);
  endtask

  task automatic measureFrame(input int idx, input int d, input string req);
    int c;
    waitFall(idx, c);
    frameStats(idx, d, req);
  endtask

  task automatic polarityRun(output int edgeChg, output int midChg);
    logic a, c, prevC;
    edgeChg = 0; midChg = 0;
    @(negedge mclk); #1;
    prevC = b0;
    for (int k = 0; k < 64; k++) begin
      @(posedge mclk); #1;
      a = b0;
      if (a != prevC) edgeChg++;
      @(negedge mclk); #1;
      c = b0;
      if (c != a) midChg++;
      prevC = c;
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) tick();
    rstN = 1'b1;
  endtask

  initial begin
    #(4 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int c, e, m;
    rstN = 1'b0; code = 3'b010; master = 1'b1; inv = 1'b0;
    repeat (3) tick();
    // R1: reset holds everything quiet even with master requested
    check(!bo0 && !lo0 && !b0 && !l0, "R1 reset quiet u0", {bo0, lo0, b0, l0}, 0);
    check(!bo1 && !lo1 && !b1 && !l1, "R1 reset quiet u1", {bo1, lo1, b1, l1}, 0);

    master = 1'b0;
    rstN = 1'b1;
    repeat (40) tick();
    // R1: slave mode stays quiet
    check(!bo0 && !b0 && !l0, "R1 slave quiet", {bo0, b0, l0}, 0);

    // R9 / R2: start master, fresh frame starts on next edge
    master = 1'b1;
    tick();
    check(oeOf(0) == 1'b1, "R2 enables after start", int'(oeOf(0)), 1);
    check(!b0 && !l0, "R9 start levels", {b0, l0}, 0);
    waitFall(0, c);
    check(c == 256, "R9 first frame from start", c, 256);

    // Table of rate codes for both builds
    for (int v = 0; v < 8; v++) begin
      code = 3'(VEC[v][0]);
      measureFrame(0, VEC[v][1], (v >= 6) ? "R5" : "R3");
      measureFrame(1, VEC[v][2], "R4");
    end

    // R8: mid-frame rate change
    code = 3'b010;
    measureFrame(0, 4, "R8 settle");
    waitFall(0, c);
    code = 3'b101;
    waitFall(0, c);
    check(c == 256, "R8 current frame keeps old ratio", c, 256);
    frameStats(0, 12, "R8 new ratio");

    // R9: master drop mid-frame
    waitFall(0, c);
    master = 1'b0;
    c = 0;
    for (int k = 0; k < 2000; k++) begin
      tick();
      c++;
      if (!oeOf(0)) break;
    end
    check(c == 768, "R9 enables held until frame end", c, 768);
    check(!b0 && !l0, "R1 outputs low after drop", {b0, l0}, 0);

    // R10: edge selection by invert input
    code = 3'b010; master = 1'b1; inv = 1'b0;
    doReset();
    repeat (10) tick();
    polarityRun(e, m);
    check(m == 0, "R10 no change mid-cycle when not inverted", m, 0);
    check(e > 0, "R10 changes on rising edge", e, 64);
    rstN = 1'b0;
    inv = 1'b1;
    doReset();
    repeat (10) tick();
    polarityRun(e, m);
    check(e == 0, "R10 no change at rising edge when inverted", e, 0);
    check(m > 0, "R10 changes on falling edge", m, 64);
    measureFrame(0, 4, "R10 inverted frame");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule